// File: doc/BRIEF.md
# Synchronous-RAM Register File with Write Forwarding

This block is the integer register file of a processor pipeline. It is built for FPGA fabrics whose embedded memories can only be read synchronously. A RAM read returns data one clock after the address. The issue logic therefore presents each read address one cycle before the operand is needed, and the data arrives on the read port in the cycle where it is consumed. Seen from the pipeline, the file behaves like an asynchronous one whose read address was applied a cycle late.

Each write port owns a private RAM bank, and every bank has one read port per operand. A small live-value table remembers which write port last wrote each register. Its lookup is registered so that it lines up with the bank outputs, and it selects the bank that drives each read port. A synchronous RAM returns the old contents when a location is read on the same edge on which it is written. To cover that case, a forwarding register per write port keeps the most recent write's address and data for one cycle. A match against the registered read address replaces the bank output. Register 0 reads as zero, and writes to it are dropped.

Top module: `syncram_regfile`

## Requirements
- R1: The data for a read address presented on `rd_addr_early_i` in cycle t appears on `rd_data_o` during cycle t+1. It reflects every write whose enable was high in cycle t or earlier, and no write from cycle t+1.
- R2: A read of register address 0 returns all zeros on that port, whatever writes occur.
- R3: A write to register address 0 on any write port has no effect: register 0 still reads zero afterwards.
- R4: After reset every register reads zero until it is first written.
- R5: When a register is written in the same cycle that its address is presented for reading, the read port returns the newly written data one cycle later, not the old contents.
- R6: When more than one write port writes the same register in the same cycle, the port with the highest index wins, both for the forwarded read and for all later reads.
- R7: A read returns the latest value written to a register, whichever write port wrote it, including when successive writes come from different ports.
- R8: The read ports are independent: any number of them may present the same or different addresses in the same cycle, and each returns the correct value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_addr_early_i | input | NUM_RD x ADDR_W | Read addresses, one per read port, given one cycle before the data is used |
| rd_data_o | output | NUM_RD x DATA_W | Read data, one per read port, valid the cycle after its address |
| wr_en_i | input | NUM_WR | Write enable, one bit per write port |
| wr_addr_i | input | NUM_WR x ADDR_W | Write address per write port |
| wr_data_i | input | NUM_WR x DATA_W | Write data per write port |

## Verification
The bench targets a read of a register in the very cycle it is written. A design without working forwarding would return the stale value that the synchronous RAM sampled on the write edge. It also issues same-cycle writes to one register from both ports. Getting the priority wrong shows up as the lower port's value, either immediately or only later, once the live-value table has been updated. Alternating writes from different ports followed by a delayed read catch a stale or misaligned bank selector, which would surface as an older value from the other bank. Writes to register 0, and reads right after reset, expose a design that stores into register 0 or lets uninitialised bank contents leak out.

// File: rtl/syncram_rf_pkg.sv
package syncram_rf_pkg;

   // Origin of the word driven on a read port
   typedef enum logic [1:0] {
      SRC_ZERO = 2'd0,
      SRC_FWD  = 2'd1,
      SRC_BANK = 2'd2
   } rd_src_e;

endpackage

// File: rtl/srf_bank.sv
// One synchronous-read RAM bank: a single write port, NUM_RD read ports.
// Read-first behaviour: a read and a write to one location on the same
// edge return the old contents.
module srf_bank #(
   parameter int unsigned NUM_RD   = 2,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 32,
   parameter int unsigned ADDR_W   = $clog2(NUM_REGS)
) (
   input  logic                           clk_i,
   input  logic                           rst_ni,
   input  logic                           wr_en_i,
   input  logic [ADDR_W-1:0]              wr_addr_i,
   input  logic [DATA_W-1:0]              wr_data_i,
   input  logic [NUM_RD-1:0][ADDR_W-1:0]  rd_addr_i,
   output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data_o
);

   logic [DATA_W-1:0] mem_q [NUM_REGS];
   logic [NUM_RD-1:0][DATA_W-1:0] rd_q;

   always_ff @(posedge clk_i) begin
      if (wr_en_i) begin
         mem_q[wr_addr_i] <= wr_data_i;
      end
      for (int r = 0; r < NUM_RD; r++) begin
         rd_q[r] <= mem_q[rd_addr_i[r]];
      end
   end

   assign rd_data_o = rd_q;

   // R7
   bank_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(wr_en_i)) |-> mem_q[$past(wr_addr_i)] == $past(wr_data_i));

endmodule

// File: rtl/srf_live_table.sv
// Live-value table: one one-hot owner vector per register, naming the write
// port whose bank holds its current value. Lookups are registered to align
// with the bank read latency.
module srf_live_table #(
   parameter int unsigned NUM_RD   = 2,
   parameter int unsigned NUM_WR   = 2,
   parameter int unsigned NUM_REGS = 32,
   parameter int unsigned ADDR_W   = $clog2(NUM_REGS)
) (
   input  logic                           clk_i,
   input  logic                           rst_ni,
   input  logic [NUM_WR-1:0]              wr_en_i,
   input  logic [NUM_WR-1:0][ADDR_W-1:0]  wr_addr_i,
   input  logic [NUM_RD-1:0][ADDR_W-1:0]  rd_addr_i,
   output logic [NUM_RD-1:0][NUM_WR-1:0]  rd_owner_o
);

   localparam logic [NUM_WR-1:0] TOP_PORT_MASK = NUM_WR'(1) << (NUM_WR - 1);

   logic [NUM_WR-1:0] owner_q [NUM_REGS];
   logic [NUM_RD-1:0][NUM_WR-1:0] rd_owner_q;

   // Later ports in the loop overwrite earlier ones: highest index wins.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < NUM_REGS; i++) begin
            owner_q[i] <= '0;
         end
         rd_owner_q <= '0;
      end else begin
         for (int w = 0; w < NUM_WR; w++) begin
            if (wr_en_i[w]) begin
               owner_q[wr_addr_i[w]] <= NUM_WR'(1) << w;
            end
         end
         for (int r = 0; r < NUM_RD; r++) begin
            rd_owner_q[r] <= owner_q[rd_addr_i[r]];
         end
      end
   end

   assign rd_owner_o = rd_owner_q;

   generate
      for (genvar r = 0; r < NUM_RD; r++) begin : g_owner_chk
         // R7
         owner_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $onehot0(rd_owner_q[r]));
      end
   endgenerate

   // R6
   owner_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(wr_en_i[NUM_WR-1]))
         |-> owner_q[$past(wr_addr_i[NUM_WR-1])] == TOP_PORT_MASK);

endmodule

// File: rtl/srf_fwd.sv
// Forwarding stage: keeps each write port's last write for one cycle and
// matches it against the registered read addresses.
module srf_fwd #(
   parameter int unsigned NUM_RD   = 2,
   parameter int unsigned NUM_WR   = 2,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 32,
   parameter int unsigned ADDR_W   = $clog2(NUM_REGS)
) (
   input  logic                           clk_i,
   input  logic                           rst_ni,
   input  logic [NUM_WR-1:0]              wr_en_i,
   input  logic [NUM_WR-1:0][ADDR_W-1:0]  wr_addr_i,
   input  logic [NUM_WR-1:0][DATA_W-1:0]  wr_data_i,
   input  logic [NUM_RD-1:0][ADDR_W-1:0]  rd_addr_i,
   output logic [NUM_RD-1:0][ADDR_W-1:0]  rd_addr_q_o,
   output logic [NUM_RD-1:0]              hit_o,
   output logic [NUM_RD-1:0][DATA_W-1:0]  fwd_data_o
);

   logic [NUM_WR-1:0]             hold_vld_q;
   logic [NUM_WR-1:0][ADDR_W-1:0] hold_addr_q;
   logic [NUM_WR-1:0][DATA_W-1:0] hold_data_q;
   logic [NUM_RD-1:0][ADDR_W-1:0] rd_addr_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hold_vld_q  <= '0;
         hold_addr_q <= '0;
         hold_data_q <= '0;
         rd_addr_q   <= '0;
      end else begin
         hold_vld_q <= wr_en_i;
         rd_addr_q  <= rd_addr_i;
         for (int w = 0; w < NUM_WR; w++) begin
            if (wr_en_i[w]) begin
               hold_addr_q[w] <= wr_addr_i[w];
               hold_data_q[w] <= wr_data_i[w];
            end
         end
      end
   end

   // Priority match: the highest matching write port supplies the data.
   always_comb begin
      hit_o      = '0;
      fwd_data_o = '0;
      for (int r = 0; r < NUM_RD; r++) begin
         for (int w = 0; w < NUM_WR; w++) begin
            if (hold_vld_q[w] && (hold_addr_q[w] == rd_addr_q[r])) begin
               hit_o[r]      = 1'b1;
               fwd_data_o[r] = hold_data_q[w];
            end
         end
      end
   end

   assign rd_addr_q_o = rd_addr_q;

   generate
      for (genvar r = 0; r < NUM_RD; r++) begin : g_rd_chk
         for (genvar w = 0; w < NUM_WR; w++) begin : g_wr_chk
            // R5
            fwd_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
               ($past(rst_ni) && $past(wr_en_i[w] && (wr_addr_i[w] == rd_addr_i[r])))
                  |-> hit_o[r]);
         end
      end
   endgenerate

endmodule

// File: rtl/syncram_regfile.sv
// Register file on synchronous-read RAM with early read addresses,
// per-write-port banks, a live-value bank selector and write forwarding.
module syncram_regfile
   import syncram_rf_pkg::*;
#(
   parameter int unsigned NUM_RD   = 2,
   parameter int unsigned NUM_WR   = 2,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 32,
   parameter int unsigned ADDR_W   = $clog2(NUM_REGS)
) (
   input  logic                           clk_i,
   input  logic                           rst_ni,
   input  logic [NUM_RD-1:0][ADDR_W-1:0]  rd_addr_early_i,
   output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data_o,
   input  logic [NUM_WR-1:0]              wr_en_i,
   input  logic [NUM_WR-1:0][ADDR_W-1:0]  wr_addr_i,
   input  logic [NUM_WR-1:0][DATA_W-1:0]  wr_data_i
);

   localparam int unsigned TOP_WR = NUM_WR - 1;

   // Elaboration-time parameter checks
   generate
      if (NUM_RD < 1 || NUM_WR < 1) begin : g_bad_ports
         initial $fatal(1, "syncram_regfile: needs at least one read and one write port");
      end
      if (DATA_W < 1) begin : g_bad_width
         initial $fatal(1, "syncram_regfile: DATA_W must be positive");
      end
      if (NUM_REGS < 2 || (1 << ADDR_W) != NUM_REGS) begin : g_bad_depth
         initial $fatal(1, "syncram_regfile: NUM_REGS must be a power of two, ADDR_W its log2");
      end
   endgenerate

   // Writes to register 0 are dropped before reaching any storage.
   logic [NUM_WR-1:0] wr_en_eff;
   generate
      for (genvar w = 0; w < NUM_WR; w++) begin : g_wr_gate
         assign wr_en_eff[w] = wr_en_i[w] && (wr_addr_i[w] != '0);
      end
   endgenerate

   // One bank per write port
   logic [NUM_WR-1:0][NUM_RD-1:0][DATA_W-1:0] bank_rd;
   generate
      for (genvar w = 0; w < NUM_WR; w++) begin : g_bank
         srf_bank #(
            .NUM_RD   (NUM_RD),
            .DATA_W   (DATA_W),
            .NUM_REGS (NUM_REGS),
            .ADDR_W   (ADDR_W)
         ) u_bank (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .wr_en_i   (wr_en_eff[w]),
            .wr_addr_i (wr_addr_i[w]),
            .wr_data_i (wr_data_i[w]),
            .rd_addr_i (rd_addr_early_i),
            .rd_data_o (bank_rd[w])
         );
      end
   endgenerate

   logic [NUM_RD-1:0][NUM_WR-1:0] rd_owner;
   srf_live_table #(
      .NUM_RD   (NUM_RD),
      .NUM_WR   (NUM_WR),
      .NUM_REGS (NUM_REGS),
      .ADDR_W   (ADDR_W)
   ) u_live (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en_eff),
      .wr_addr_i  (wr_addr_i),
      .rd_addr_i  (rd_addr_early_i),
      .rd_owner_o (rd_owner)
   );

   logic [NUM_RD-1:0][ADDR_W-1:0] rd_addr_q;
   logic [NUM_RD-1:0]             fwd_hit;
   logic [NUM_RD-1:0][DATA_W-1:0] fwd_data;
   srf_fwd #(
      .NUM_RD   (NUM_RD),
      .NUM_WR   (NUM_WR),
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS),
      .ADDR_W   (ADDR_W)
   ) u_fwd (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_en_i     (wr_en_eff),
      .wr_addr_i   (wr_addr_i),
      .wr_data_i   (wr_data_i),
      .rd_addr_i   (rd_addr_early_i),
      .rd_addr_q_o (rd_addr_q),
      .hit_o       (fwd_hit),
      .fwd_data_o  (fwd_data)
   );

   // Output selection per read port
   rd_src_e [NUM_RD-1:0]          rd_src;
   logic [NUM_RD-1:0][DATA_W-1:0] bank_sel;

   always_comb begin
      for (int r = 0; r < NUM_RD; r++) begin
         bank_sel[r] = '0;
         for (int w = 0; w < NUM_WR; w++) begin
            bank_sel[r] = bank_sel[r] | (bank_rd[w][r] & {DATA_W{rd_owner[r][w]}});
         end
         if (rd_addr_q[r] == '0) begin
            rd_src[r] = SRC_ZERO;
         end else if (fwd_hit[r]) begin
            rd_src[r] = SRC_FWD;
         end else begin
            rd_src[r] = SRC_BANK;
         end
         unique case (rd_src[r])
            SRC_FWD:  rd_data_o[r] = fwd_data[r];
            SRC_BANK: rd_data_o[r] = bank_sel[r];
            default:  rd_data_o[r] = '0;
         endcase
      end
   end

   generate
      for (genvar r = 0; r < NUM_RD; r++) begin : g_port_chk
         // R2
         zero_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($past(rst_ni) && ($past(rd_addr_early_i[r]) == '0)) |-> (rd_data_o[r] == '0));

         // R5 / R6
         raw_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($past(rst_ni) && $past(wr_en_i[TOP_WR] && (wr_addr_i[TOP_WR] != '0)
                                    && (wr_addr_i[TOP_WR] == rd_addr_early_i[r])))
               |-> (rd_data_o[r] == $past(wr_data_i[TOP_WR])));
      end
   endgenerate

endmodule

// File: tb/syncram_regfile_bench.sv
`timescale 1ns/1ps
module syncram_regfile_bench;

   localparam int NRD  = 2;
   localparam int NWR  = 2;
   localparam int DW   = 32;
   localparam int NREG = 32;
   localparam int AW   = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NRD-1:0][AW-1:0] ra = '0;
   logic [NRD-1:0][DW-1:0] rd;
   logic [NWR-1:0]         we = '0;
   logic [NWR-1:0][AW-1:0] wa = '0;
   logic [NWR-1:0][DW-1:0] wd = '0;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   logic [DW-1:0] model [NREG];

   always #10 clk = ~clk;

   syncram_regfile #(
      .NUM_RD   (NRD),
      .NUM_WR   (NWR),
      .DATA_W   (DW),
      .NUM_REGS (NREG),
      .ADDR_W   (AW)
   ) u_syncram_regfile (
      .clk_i           (clk),
      .rst_ni          (rst_n),
      .rd_addr_early_i (ra),
      .rd_data_o       (rd),
      .wr_en_i         (we),
      .wr_addr_i       (wa),
      .wr_data_i       (wd)
   );

   task automatic check(input string tag, input int port, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s port %0d: actual %08h expected %08h", tag, port, act, exp);
      end
   endtask

   // Apply the current inputs for one cycle, update the reference model and
   // compare the read ports one cycle later (at the next falling edge).
   task automatic step(input string tag);
      string tg [NRD];
      logic [DW-1:0] exp [NRD];
      for (int r = 0; r < NRD; r++) begin
         int nw = 0;
         for (int w = 0; w < NWR; w++) begin
            if (we[w] && wa[w] == ra[r] && ra[r] != 0) nw++;
         end
         tg[r] = tag;
         if (nw == 1) tg[r] = "R5";
         if (nw > 1)  tg[r] = "R6";
      end
      for (int w = 0; w < NWR; w++) begin
         if (we[w] && wa[w] != 0) model[wa[w]] = wd[w];
      end
      for (int r = 0; r < NRD; r++) begin
         exp[r] = (ra[r] == 0) ? '0 : model[ra[r]];
      end
      @(negedge clk);
      for (int r = 0; r < NRD; r++) begin
         check(tg[r], r, rd[r], exp[r]);
      end
   endtask

   task automatic quiet();
      we = '0;
      wa = '0;
      wd = '0;
   endtask

   initial begin
      for (int i = 0; i < NREG; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R4: reset state on the ports
      for (int r = 0; r < NRD; r++) check("R4", r, rd[r], '0);

      // R4: every register reads zero before being written
      for (int a = 0; a < NREG; a++) begin
         ra[0] = AW'(a);
         ra[1] = AW'(NREG - 1 - a);
         step("R4");
      end

      // R1: fill through both ports, read back two cycles later (bank path)
      for (int a = 1; a < NREG + 2; a++) begin
         quiet();
         if (a < NREG) begin
            we[a % 2] = 1'b1;
            wa[a % 2] = AW'(a);
            wd[a % 2] = 32'hA500_0000 + 32'(a * 97);
         end
         ra[0] = AW'((a > 2) ? a - 2 : 1);
         ra[1] = AW'((a > 3) ? a - 3 : 2);
         step("R1");
      end

      // R1: a write in the output cycle is not visible in that output
      quiet();
      ra[0] = 5'd7; ra[1] = 5'd8;
      step("R1");
      we[0] = 1'b1; wa[0] = 5'd7; wd[0] = 32'h1111_2222;
      ra[0] = 5'd8; ra[1] = 5'd7;
      step("R1");

      // R3: writes to register 0 on both ports, then read it
      quiet();
      we = '1; wa[0] = 5'd0; wa[1] = 5'd0; wd[0] = 32'hDEAD_BEEF; wd[1] = 32'hFFFF_FFFF;
      ra[0] = 5'd0; ra[1] = 5'd0;
      step("R3");
      quiet();
      step("R3");

      // R2: read register 0 while other registers are written
      for (int i = 0; i < 4; i++) begin
         quiet();
         we = '1; wa[0] = AW'(3 + i); wa[1] = AW'(10 + i);
         wd[0] = 32'h0F0F_0000 + 32'(i); wd[1] = 32'hF0F0_0000 + 32'(i);
         ra = '0;
         step("R2");
      end

      // R5: read in the same cycle as the write, on each write port
      for (int i = 0; i < 6; i++) begin
         quiet();
         we[i % 2] = 1'b1; wa[i % 2] = AW'(20 + i); wd[i % 2] = 32'h5A5A_0000 + 32'(i);
         ra[0] = AW'(20 + i); ra[1] = AW'(20 + i);
         step("R5");
      end

      // R6: both ports write one register in the same cycle
      for (int i = 0; i < 3; i++) begin
         quiet();
         we = '1; wa[0] = 5'd14; wa[1] = 5'd14;
         wd[0] = 32'h0000_1000 + 32'(i); wd[1] = 32'h0000_2000 + 32'(i);
         ra[0] = 5'd14; ra[1] = 5'd2;
         step("R6");
         quiet();
         ra[0] = 5'd2; ra[1] = 5'd14;
         step("R6");
         step("R6");
      end

      // R7: successive writes alternate ports, read via the bank path
      for (int i = 0; i < 8; i++) begin
         quiet();
         we[i % 2] = 1'b1; wa[i % 2] = 5'd9; wd[i % 2] = 32'h7700_0000 + 32'(i * 3);
         ra[0] = 5'd1; ra[1] = 5'd2;
         step("R7");
         quiet();
         ra[0] = 5'd9; ra[1] = 5'd9;
         step("R7");
      end

      // R8: both read ports on the same and on different registers
      for (int i = 1; i < 8; i++) begin
         quiet();
         ra[0] = AW'(i); ra[1] = AW'(i);
         step("R8");
         ra[0] = AW'(i); ra[1] = AW'(NREG - i);
         step("R8");
      end

      // R1 with overrides: random traffic, addresses biased to collide
      for (int n = 0; n < 3000; n++) begin
         for (int w = 0; w < NWR; w++) begin
            we[w] = ($urandom_range(0, 2) != 0);
            wa[w] = ($urandom_range(0, 3) == 0) ? AW'($urandom_range(0, NREG - 1))
                                                : AW'($urandom_range(0, 5));
            wd[w] = $urandom;
         end
         for (int r = 0; r < NRD; r++) begin
            ra[r] = ($urandom_range(0, 3) == 0) ? AW'($urandom_range(0, NREG - 1))
                                                : AW'($urandom_range(0, 5));
         end
         step("R1");
      end

      quiet();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule